// File: doc/BRIEF.md
# Dual-Buffer Transmit Command Controller

This block is the register-mapped transmit side of a small Ethernet MAC. Software fills one of two packet buffers through a 32-bit word bus, writes that buffer's length word and then writes its control word. The control word carries a start bit and a program bit. Start alone streams the buffer out as a byte frame. Start with program copies the first six bytes of the buffer into the station address register. Both bits read back as set while the command runs and clear themselves when it completes.

On completion the block raises a one-cycle interrupt pulse. The pulse fires only if the buffer's own interrupt bit is set and bit 31 of the single global enable word is set. That word lives beside buffer 0, and buffer 1 has no enable word of its own. Frame bytes leave on a valid/ready/last byte stream. Preamble, checksum, line coding and collisions belong to later stages.

Top module: `txcmd_ctrl`

## Requirements
- R1: After reset, irq and tx_valid are 0, station_addr is 0, and the control, length and enable words read 0.
- R2: Buffer 0 spans byte offsets 0x000 to 0x7F3 and buffer 1 spans 0x800 to 0xFF3, both as 509 storage words. The length words sit at 0x7F4 and 0xFF4, the control words at 0x7FC and 0xFFC, and the enable word at 0x7F8. A write whose address bits [1:0] are not 00 changes nothing, and a read at such an address returns 0. Read data appears on bus_rdata the cycle after bus_rd.
- R3: A control write with bit 0 = 1 and bit 1 = 0 sends min(length[15:0], 2036) bytes. Byte k is bits [8*(k mod 4)+7 : 8*(k mod 4)] of storage word k/4. tx_last is high on the final byte only. A length of 0 completes without sending a byte.
- R4: A control write with bit 0 = 1 and bit 1 = 1 loads station_addr bits [8i+7:8i] with buffer byte i, for i = 0 to 5, and completes in one cycle.
- R5: The control word reads as bit 3 = the stored interrupt bit, bit 0 = 1 while a command runs, bit 1 = 1 while an address load runs, and all other bits 0. A control write with bit 0 = 0 only updates bit 3 and starts nothing.
- R6: While a buffer's command runs, writes to that buffer's storage, length and control words are ignored.
- R7: Completion of a command gives a one-cycle irq pulse if and only if the buffer's bit 3 is set and enable bit 31 is set. The enable word reads back only bit 31.
- R8: Offset 0xFF8 is not an enable word: writes to it have no effect and it reads 0. Buffer 1 interrupts are gated by 0x7F8.
- R9: When completions on both buffers fall in the same cycle, irq pulses exactly once, for one cycle.
- R10: A send started while the other buffer is streaming begins only after that frame's last byte. Frames never interleave.
- R11: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Completion interrupt pulse |
| station_addr | output | 48 | Station MAC address, byte 0 in bits [7:0] |

## Verification
The two functions that can complete in the same cycle are an address load on one buffer and the acceptance of the final frame byte from the other buffer. The bench holds tx_ready low while a one-byte frame from buffer 0 waits on the stream. It then issues an address-load command to buffer 1 and raises tx_ready on the cycle the load executes, so both completions land on one edge. The outcome is judged by the irq pulse count and pulse width, both expected to be one. The captured byte, the new station address and both control readbacks must also be correct.

// File: rtl/txcmd_pkg.sv
package txcmd_pkg;
    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_PROG_BIT  = 1;
    localparam int CTRL_IEN_BIT   = 3;
    localparam int GIE_BIT        = 31;
    localparam int LEN_REG_W      = 16;
    localparam int MAC_W          = 48;

    typedef struct packed {
        logic                 busy;
        logic                 is_mac;
        logic                 ien;
        logic [LEN_REG_W-1:0] len;
    } bufst_t;
endpackage

// File: rtl/txcmd_bufctl.sv
module txcmd_bufctl
    import txcmd_pkg::*;
#(
    parameter int BUF_WORDS = 512
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [$clog2(BUF_WORDS)-1:0]      idx,
    input  logic [31:0]                       wr_data,
    output logic [31:0]                       rd_word,
    input  logic [$clog2(BUF_WORDS*4)-1:0]    byte_idx,
    output logic [7:0]                        byte_out,
    output logic [MAC_W-1:0]                  mac_out,
    output logic                              send_req,
    output logic                              mac_req,
    output logic                              ien,
    output logic [$clog2(BUF_WORDS*4)-1:0]    len_eff,
    input  logic                              send_done
);
    localparam int IDX_W      = $clog2(BUF_WORDS);
    localparam int BYTE_W     = $clog2(BUF_WORDS * 4);
    localparam int DATA_WORDS = BUF_WORDS - 3;
    localparam int DATA_BYTES = DATA_WORDS * 4;
    localparam int LEN_IDX    = BUF_WORDS - 3;
    localparam int CTRL_IDX   = BUF_WORDS - 1;

    bufst_t st_q, st_d;
    logic [31:0] mem_q [DATA_WORDS];

    logic             wr_ok;
    logic [IDX_W-1:0] bw_idx;

    assign wr_ok  = wr_en && !st_q.busy;
    assign bw_idx = byte_idx[BYTE_W-1:2];

    always_comb begin
        st_d = st_q;
        if (st_q.busy && st_q.is_mac) st_d.busy = 1'b0;
        if (send_done)                st_d.busy = 1'b0;
        if (wr_ok) begin
            if (int'(idx) == LEN_IDX) st_d.len = wr_data[LEN_REG_W-1:0];
            if (int'(idx) == CTRL_IDX) begin
                st_d.ien = wr_data[CTRL_IEN_BIT];
                if (wr_data[CTRL_START_BIT]) begin
                    st_d.busy   = 1'b1;
                    st_d.is_mac = wr_data[CTRL_PROG_BIT];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok && int'(idx) < DATA_WORDS) mem_q[idx] <= wr_data;
    end

    always_comb begin
        rd_word = '0;
        if (int'(idx) < DATA_WORDS)  rd_word = mem_q[idx];
        else if (int'(idx) == LEN_IDX)  rd_word = {{(32-LEN_REG_W){1'b0}}, st_q.len};
        else if (int'(idx) == CTRL_IDX) begin
            rd_word[CTRL_IEN_BIT]   = st_q.ien;
            rd_word[CTRL_START_BIT] = st_q.busy;
            rd_word[CTRL_PROG_BIT]  = st_q.busy && st_q.is_mac;
        end
    end

    logic [31:0] bword;
    always_comb begin
        bword    = (int'(bw_idx) < DATA_WORDS) ? mem_q[bw_idx] : '0;
        byte_out = bword[8*byte_idx[1:0] +: 8];
    end

    assign mac_out  = {mem_q[1][15:0], mem_q[0]};
    assign send_req = st_q.busy && !st_q.is_mac;
    assign mac_req  = st_q.busy && st_q.is_mac;
    assign ien      = st_q.ien;
    assign len_eff  = (int'(st_q.len) > DATA_BYTES) ? BYTE_W'(DATA_BYTES)
                                                    : st_q.len[BYTE_W-1:0];

    // R6: a running command freezes the length and interrupt bit
    assert_busy_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> ($stable(st_q.len) && $stable(st_q.ien)));
endmodule

// File: rtl/txcmd_streamer.sv
module txcmd_streamer #(
    parameter int BYTE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        send_req,
    input  logic [BYTE_W-1:0] len_i [2],
    input  logic [7:0]        byte_in,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              sel,
    output logic [BYTE_W-1:0] byte_idx,
    output logic [1:0]        done
);
    typedef struct packed {
        logic              active;
        logic              sel;
        logic [BYTE_W-1:0] cnt;
    } strm_t;

    strm_t st_q, st_d;
    logic  at_end;
    logic  pick;

    assign at_end = (st_q.cnt == len_i[st_q.sel] - BYTE_W'(1));

    always_comb begin
        st_d = st_q;
        done = '0;
        pick = !send_req[0];
        if (!st_q.active) begin
            if (|send_req) begin
                if (len_i[pick] == '0) begin
                    done[pick] = 1'b1;
                end else begin
                    st_d.active = 1'b1;
                    st_d.sel    = pick;
                    st_d.cnt    = '0;
                end
            end
        end else if (tx_ready) begin
            if (at_end) begin
                done[st_q.sel] = 1'b1;
                st_d.active    = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + BYTE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_valid = st_q.active;
    assign tx_last  = st_q.active && at_end;
    assign tx_data  = byte_in;
    assign sel      = st_q.sel;
    assign byte_idx = st_q.cnt;

    // R11: a stalled byte holds still
    assert_hold_while_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
    // R10: a frame continues on the same buffer until its last byte
    assert_frame_continues_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_last) |=> (tx_valid && $stable(sel)));
    // R3: the stream drops valid after the last byte is taken
    assert_ends_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);
endmodule

// File: rtl/txcmd_ctrl.sv
module txcmd_ctrl
    import txcmd_pkg::*;
#(
    parameter int BUF_BYTES = 2048
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [$clog2(BUF_BYTES):0]      bus_addr,
    input  logic                            bus_wr,
    input  logic [31:0]                     bus_wdata,
    input  logic                            bus_rd,
    output logic [31:0]                     bus_rdata,
    output logic                            tx_valid,
    output logic [7:0]                      tx_data,
    output logic                            tx_last,
    input  logic                            tx_ready,
    output logic                            irq,
    output logic [MAC_W-1:0]                station_addr
);
    localparam int BUF_WORDS = BUF_BYTES / 4;
    localparam int ADDR_W    = $clog2(BUF_BYTES) + 1;
    localparam int IDX_W     = $clog2(BUF_WORDS);
    localparam int BYTE_W    = $clog2(BUF_BYTES);
    localparam int GIE_IDX   = BUF_WORDS - 2;

    typedef struct packed {
        logic             gie;
        logic             irq;
        logic [MAC_W-1:0] mac;
        logic [31:0]      rdata;
    } top_t;

    top_t st_q, st_d;

    logic             aligned;
    logic             bsel;
    logic [IDX_W-1:0] idx;
    logic             gie_hit;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign bsel    = bus_addr[ADDR_W-1];
    assign idx     = bus_addr[ADDR_W-2:2];
    assign gie_hit = aligned && !bsel && (int'(idx) == GIE_IDX);

    logic [31:0]       rd_word  [2];
    logic [7:0]        byte_out [2];
    logic [MAC_W-1:0]  mac_out  [2];
    logic [BYTE_W-1:0] len_eff  [2];
    logic [1:0]        send_req, mac_req, ien, send_done;
    logic              s_sel;
    logic [BYTE_W-1:0] s_idx;

    for (genvar b = 0; b < 2; b++) begin : g_buf
        txcmd_bufctl #(.BUF_WORDS(BUF_WORDS)) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (bus_wr && aligned && (bsel == b[0])),
            .idx       (idx),
            .wr_data   (bus_wdata),
            .rd_word   (rd_word[b]),
            .byte_idx  (s_idx),
            .byte_out  (byte_out[b]),
            .mac_out   (mac_out[b]),
            .send_req  (send_req[b]),
            .mac_req   (mac_req[b]),
            .ien       (ien[b]),
            .len_eff   (len_eff[b]),
            .send_done (send_done[b])
        );
    end

    txcmd_streamer #(.BYTE_W(BYTE_W)) u_strm (
        .clk      (clk),
        .rst_n    (rst_n),
        .send_req (send_req),
        .len_i    (len_eff),
        .byte_in  (byte_out[s_sel]),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_last  (tx_last),
        .sel      (s_sel),
        .byte_idx (s_idx),
        .done     (send_done)
    );

    always_comb begin
        st_d = st_q;
        if (bus_wr && gie_hit) st_d.gie = bus_wdata[GIE_BIT];
        if (mac_req[0])      st_d.mac = mac_out[0];
        else if (mac_req[1]) st_d.mac = mac_out[1];
        st_d.irq = st_q.gie && |((mac_req | send_done) & ien);
        if (bus_rd) begin
            if (!aligned)     st_d.rdata = '0;
            else if (gie_hit) st_d.rdata = {st_q.gie, 31'b0};
            else              st_d.rdata = rd_word[bsel];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata    = st_q.rdata;
    assign irq          = st_q.irq;
    assign station_addr = st_q.mac;

    // R7: a pulse needs the global enable one cycle earlier
    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(st_q.gie));
    // R4: the station address changes only after a load command ran
    assert_mac_only_on_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (station_addr != $past(station_addr)) |-> $past(|mac_req));
endmodule

// File: tb/txcmd_ctrl_bench.sv
module txcmd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_last, irq;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic [47:0] station_addr;

    int nchk = 0;
    int nfail = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    txcmd_ctrl u_txcmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready), .irq(irq), .station_addr(station_addr)
    );

    logic [7:0] cap [4096];
    logic       cap_last [4096];
    int         cap_n = 0;
    int         pulses = 0;
    int         hicyc = 0;
    logic       irq_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready && cap_n < 4096) begin
            cap[cap_n] = tx_data;
            cap_last[cap_n] = tx_last;
            cap_n = cap_n + 1;
        end
        if (irq && !irq_prev) pulses = pulses + 1;
        if (irq) hicyc = hicyc + 1;
        irq_prev = irq;
    end

    function automatic logic [7:0] pat(input int b, input int k);
        return 8'((k * 7 + b * 101 + 13) & 255);
    endfunction

    function automatic logic [31:0] pword(input int b, input int w);
        return {pat(b, 4*w+3), pat(b, 4*w+2), pat(b, 4*w+1), pat(b, 4*w)};
    endfunction

    function automatic logic [47:0] pmac(input int b);
        return {pat(b,5), pat(b,4), pat(b,3), pat(b,2), pat(b,1), pat(b,0)};
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #2;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clr();
        cap_n = 0; pulses = 0; hicyc = 0;
    endtask

    task automatic frame_check(input string tag, input int b, input int n, input int off);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            if (cap[off+k] !== pat(b, k)) bad++;
            if (cap_last[off+k] !== (k == n-1)) bad++;
        end
        chk(tag, 64'(bad), 64'd0);
    endtask

    function automatic logic [11:0] base(input int b);
        return (b == 1) ? 12'h800 : 12'h000;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            nfail = nfail + 1;
            $display("FAIL watchdog actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int lens [10] = '{0, 1, 2, 3, 4, 5, 7, 8, 13, 64};

        waitc(3);
        rst_n = 1'b1;
        waitc(1);

        // R1 reset state
        chk("R1 irq", 64'(irq), 0);
        chk("R1 tx_valid", 64'(tx_valid), 0);
        chk("R1 station_addr", 64'(station_addr), 0);
        rd(12'h7FC, r); chk("R1 ctrl0", 64'(r), 0);
        rd(12'hFFC, r); chk("R1 ctrl1", 64'(r), 0);
        rd(12'h7F4, r); chk("R1 len0", 64'(r), 0);
        rd(12'h7F8, r); chk("R1 enable", 64'(r), 0);

        // R2 fill both buffers and read back
        for (int b = 0; b < 2; b++)
            for (int w = 0; w < 509; w++) wr(base(b) + 12'(4*w), pword(b, w));
        for (int b = 0; b < 2; b++) begin
            rd(base(b) + 12'h000, r); chk("R2 word0", 64'(r), 64'(pword(b, 0)));
            rd(base(b) + 12'h01C, r); chk("R2 word7", 64'(r), 64'(pword(b, 7)));
            rd(base(b) + 12'h7F0, r); chk("R2 word508", 64'(r), 64'(pword(b, 508)));
        end
        wr(12'h001, 32'h12345678);
        rd(12'h000, r); chk("R2 misaligned write ignored", 64'(r), 64'(pword(0, 0)));
        rd(12'h001, r); chk("R2 misaligned read zero", 64'(r), 0);

        // R7 enable word keeps bit 31 only
        wr(12'h7F8, 32'hFFFF_FFFF);
        rd(12'h7F8, r); chk("R7 enable readback", 64'(r), 64'h8000_0000);

        // R3 send sweep on both buffers
        tx_ready = 1'b1;
        for (int b = 0; b < 2; b++) begin
            foreach (lens[i]) begin
                wr(base(b) + 12'h7F4, 32'(lens[i]));
                clr();
                wr(base(b) + 12'h7FC, 32'h9);
                waitc(lens[i] + 8);
                chk("R3 byte count", 64'(cap_n), 64'(lens[i]));
                frame_check("R3 bytes and last", b, lens[i], 0);
                chk("R7 pulse count", 64'(pulses), 1);
                chk("R7 pulse width", 64'(hicyc), 1);
                rd(base(b) + 12'h7FC, r); chk("R5 ctrl after send", 64'(r), 64'h8);
            end
        end

        // R3 length clamp
        wr(12'h7F4, 32'h0000_FFFF);
        clr();
        wr(12'h7FC, 32'h9);
        waitc(2100);
        chk("R3 clamp count", 64'(cap_n), 2036);
        frame_check("R3 clamp bytes", 0, 2036, 0);
        rd(12'h7F4, r); chk("R3 len readback", 64'(r), 64'hFFFF);

        // R4 address load from each buffer
        for (int b = 0; b < 2; b++) begin
            clr();
            wr(base(b) + 12'h7FC, 32'hB);
            waitc(4);
            chk("R4 station_addr", 64'(station_addr), 64'(pmac(b)));
            chk("R4 no frame", 64'(cap_n), 0);
            chk("R7 load pulse", 64'(pulses), 1);
            rd(base(b) + 12'h7FC, r); chk("R5 ctrl after load", 64'(r), 64'h8);
        end

        // R8 no enable word at 0xFF8
        wr(12'h7F8, 32'h0);
        wr(12'hFF8, 32'h8000_0000);
        rd(12'hFF8, r); chk("R8 0xFF8 reads zero", 64'(r), 0);
        rd(12'h7F8, r); chk("R8 enable untouched", 64'(r), 0);

        // R7 and R8 gating sweep
        for (int b = 0; b < 2; b++) begin
            wr(base(b) + 12'h7F4, 32'd2);
            for (int m = 0; m < 2; m++)
                for (int ie = 0; ie < 2; ie++)
                    for (int g = 0; g < 2; g++) begin
                        wr(12'h7F8, g ? 32'h8000_0000 : 32'h0);
                        clr();
                        wr(base(b) + 12'h7FC, 32'(1 + 2*m + 8*ie));
                        waitc(8);
                        chk(b ? "R8 buffer1 gating" : "R7 buffer0 gating",
                            64'(pulses), 64'(ie & g));
                    end
        end
        wr(12'h7F8, 32'h8000_0000);

        // R6 and R11: writes during a stalled send
        tx_ready = 1'b0;
        wr(12'h7F4, 32'd4);
        clr();
        wr(12'h7FC, 32'h9);
        waitc(3);
        rd(12'h7FC, r); chk("R5 busy readback", 64'(r), 64'h9);
        wr(12'h7F4, 32'd9);
        wr(12'h7FC, 32'h0);
        wr(12'h000, 32'hDEAD_BEEF);
        rd(12'h7F4, r); chk("R6 len frozen", 64'(r), 4);
        rd(12'h7FC, r); chk("R6 ctrl frozen", 64'(r), 64'h9);
        chk("R11 valid held", 64'(tx_valid), 1);
        chk("R11 data held", 64'(tx_data), 64'(pat(0, 0)));
        tx_ready = 1'b1;
        waitc(10);
        chk("R6 frame count", 64'(cap_n), 4);
        frame_check("R6 frame unchanged", 0, 4, 0);
        rd(12'h000, r); chk("R6 word0 unchanged", 64'(r), 64'(pword(0, 0)));

        // R5 program bit without start
        clr();
        wr(12'h7FC, 32'h2);
        waitc(6);
        chk("R5 no command", 64'(cap_n + pulses), 0);
        rd(12'h7FC, r); chk("R5 ctrl bit3 only", 64'(r), 0);
        wr(12'h7FC, 32'h8);

        // R10 queued sends do not interleave
        tx_ready = 1'b0;
        wr(12'h7F4, 32'd3);
        wr(12'hFF4, 32'd2);
        clr();
        wr(12'h7FC, 32'h9);
        wr(12'hFFC, 32'h9);
        waitc(2);
        tx_ready = 1'b1;
        waitc(12);
        chk("R10 total bytes", 64'(cap_n), 5);
        frame_check("R10 first frame", 0, 3, 0);
        frame_check("R10 second frame", 1, 2, 3);
        chk("R10 pulses", 64'(pulses), 2);

        // R9 coincident completion
        tx_ready = 1'b0;
        wr(12'h7F4, 32'd1);
        wr(12'h0000, pword(0, 0));
        clr();
        wr(12'h7FC, 32'h9);
        waitc(3);
        wr(12'hFFC, 32'hB);
        tx_ready = 1'b1;
        waitc(6);
        chk("R9 pulse count", 64'(pulses), 1);
        chk("R9 pulse width", 64'(hicyc), 1);
        chk("R9 byte count", 64'(cap_n), 1);
        frame_check("R9 byte", 0, 1, 0);
        chk("R9 station_addr", 64'(station_addr), 64'(pmac(1)));
        rd(12'h7FC, r); chk("R9 ctrl0", 64'(r), 64'h8);
        rd(12'hFFC, r); chk("R9 ctrl1", 64'(r), 64'h8);

        done_flag = 1;
        summary();
        $finish;
    end
endmodule